// File: doc/BRIEF.md
# Rung-Edge Up/Down Event Counter

This block counts events the way an industrial controller counter instruction does. It has two rung-condition inputs, one for counting up and one for counting down. Each input changes a signed two's-complement accumulator by one, but only on the clock in which it goes from low to high. A level that stays high adds nothing more.

The accumulator does not stop at the set point. It keeps counting in either direction and wraps at the ends of the signed range. Each wrap sets a sticky overflow or underflow flag. A done flag reports the signed comparison of the accumulator against a programmable preset word. Two enable flags show the level of each rung input. A synchronous clear command zeroes the count and all three status flags. A controller uses the block by driving its rung conditions into the two count inputs and reading the accumulator and flags back each scan.

Top module: `rung_counter`

## Requirements
- R1: After the asynchronous active-low reset, the accumulator, done, overflow, underflow and both enable flags all read zero.
- R2: The accumulator rises by one on the clock edge where the up input is high and was low at the previous edge. Holding the input high for further clocks leaves the count unchanged.
- R3: The accumulator falls by one on the clock edge where the down input is high and was low at the previous edge. Holding the input high leaves the count unchanged.
- R4: An up edge taken at the largest positive value (2^(W-1)-1) wraps the accumulator to the most negative value (-2^(W-1)) and sets the overflow flag. Later up edges keep counting upward from there.
- R5: A down edge taken at the most negative value wraps the accumulator to the largest positive value and sets the underflow flag. Later down edges keep counting downward.
- R6: Once set, the overflow and underflow flags stay set through any number of count edges. Only the clear command or reset lowers them.
- R7: A clock edge with the clear command high forces the accumulator to zero and lowers done, overflow and underflow. This holds even when a count edge arrives in the same clock.
- R8: When rising edges arrive on both count inputs in the same clock, the accumulator is left unchanged.
- R9: At each clock edge without clear, done is loaded with (value written to the accumulator at that edge >= the preset input), compared as signed numbers. Counting continues past the preset in both directions.
- R10: Each enable flag holds the level of its count input as sampled at the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| countUpIn | input | 1 | Count-up rung condition |
| countDnIn | input | 1 | Count-down rung condition |
| clearCmd | input | 1 | Synchronous clear of count and status |
| presetIn | input | W | Signed set point |
| accOut | output | W | Signed accumulated count |
| doneOut | output | 1 | Accumulator >= preset (signed) |
| ovfOut | output | 1 | Sticky overflow flag |
| udfOut | output | 1 | Sticky underflow flag |
| upEnOut | output | 1 | Registered level of count-up input |
| dnEnOut | output | 1 | Registered level of count-down input |

## Verification
The assertions assume that the rung inputs, the clear command and the preset are synchronous to the clock and settled before each rising edge. They also assume that reset is asserted only to start a run. The bench keeps to this by changing every input on the falling edge and pulsing reset once at the start. The sweep runs a narrow accumulator through every preset value in its range. This pushes the count across both wrap points and past the preset in each direction.

// File: rtl/rung_counter_pkg.sv
package rung_counter_pkg;

  // Strobes from control to datapath; at most one of incr/decr per clock.
  typedef struct packed {
    logic incr;
    logic decr;
    logic clear;
  } cntStrobe_t;

endpackage

// File: rtl/rung_counter_ctrl.sv
module rung_counter_ctrl
  import rung_counter_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       countUpIn,
  input  logic       countDnIn,
  input  logic       clearCmd,
  output cntStrobe_t strobe,
  output logic       upEnOut,
  output logic       dnEnOut
);

  localparam int NumLanes = 2;

  logic [NumLanes-1:0] laneLvl;
  logic [NumLanes-1:0] lanePrev;
  logic [NumLanes-1:0] laneRise;

  assign laneLvl = {countDnIn, countUpIn};

  // One edge detector per rung input.
  for (genvar g = 0; g < NumLanes; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lanePrev[g] <= 1'b0;
      else        lanePrev[g] <= laneLvl[g];
    end
    assign laneRise[g] = laneLvl[g] & ~lanePrev[g];
  end

  // Clear wins; simultaneous edges cancel.
  always_comb begin
    strobe.clear = clearCmd;
    strobe.incr  = !clearCmd && laneRise[0] && !laneRise[1];
    strobe.decr  = !clearCmd && laneRise[1] && !laneRise[0];
  end

  assign upEnOut = lanePrev[0];
  assign dnEnOut = lanePrev[1];

  AST_ENABLE_TRACKS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> upEnOut == $past(countUpIn)); // R10
  AST_HELD_LEVEL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (countUpIn && upEnOut && !countDnIn) |-> !strobe.incr); // R2

endmodule

// File: rtl/rung_counter_dp.sv
module rung_counter_dp
  import rung_counter_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cntStrobe_t   strobe,
  input  logic [W-1:0] presetIn,
  output logic [W-1:0] accOut,
  output logic         doneOut,
  output logic         ovfOut,
  output logic         udfOut
);

  localparam logic [W-1:0] MaxVal = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MinVal = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] accQ, accNext;
  logic         ovfQ, udfQ, doneQ;
  logic         wrapUp, wrapDn;

  assign wrapUp = strobe.incr && (accQ == MaxVal);
  assign wrapDn = strobe.decr && (accQ == MinVal);

  always_comb begin
    accNext = accQ;
    if (strobe.clear)     accNext = '0;
    else if (strobe.incr) accNext = accQ + 1'b1;
    else if (strobe.decr) accNext = accQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accQ  <= '0;
      ovfQ  <= 1'b0;
      udfQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      accQ  <= accNext;
      ovfQ  <= strobe.clear ? 1'b0 : (ovfQ | wrapUp);
      udfQ  <= strobe.clear ? 1'b0 : (udfQ | wrapDn);
      doneQ <= strobe.clear ? 1'b0 : ($signed(accNext) >= $signed(presetIn));
    end
  end

  assign accOut  = accQ;
  assign ovfOut  = ovfQ;
  assign udfOut  = udfQ;
  assign doneOut = doneQ;

  AST_INC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.incr && accQ != MaxVal) |=> accQ == $past(accQ) + 1'b1); // R2
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.decr && accQ != MinVal) |=> accQ == $past(accQ) - 1'b1); // R3
  AST_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.incr && accQ == MaxVal) |=> (accQ == MinVal) && ovfQ); // R4
  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.decr && accQ == MinVal) |=> (accQ == MaxVal) && udfQ); // R5
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.clear && (ovfQ || udfQ)) |=> (ovfQ || !$past(ovfQ)) && (udfQ || !$past(udfQ))); // R6
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> (accQ == '0) && !ovfQ && !udfQ && !doneQ); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.incr && !strobe.decr && !strobe.clear) |=> $stable(accQ)); // R8
  AST_DONE_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.clear |=> doneQ == ($signed(accQ) >= $signed($past(presetIn)))); // R9

endmodule

// File: rtl/rung_counter.sv
module rung_counter
  import rung_counter_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         countUpIn,
  input  logic         countDnIn,
  input  logic         clearCmd,
  input  logic [W-1:0] presetIn,
  output logic [W-1:0] accOut,
  output logic         doneOut,
  output logic         ovfOut,
  output logic         udfOut,
  output logic         upEnOut,
  output logic         dnEnOut
);

  cntStrobe_t strobe;

  rung_counter_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .countUpIn (countUpIn),
    .countDnIn (countDnIn),
    .clearCmd  (clearCmd),
    .strobe    (strobe),
    .upEnOut   (upEnOut),
    .dnEnOut   (dnEnOut)
  );

  rung_counter_dp #(.W(W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .presetIn (presetIn),
    .accOut   (accOut),
    .doneOut  (doneOut),
    .ovfOut   (ovfOut),
    .udfOut   (udfOut)
  );

  AST_BOTH_EDGES_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (countUpIn && !upEnOut && countDnIn && !dnEnOut && !clearCmd) |=> $stable(accOut)); // R8

endmodule

// File: tb/rung_counter_tb.sv
module rung_counter_tb;

  localparam int W = 4;
  localparam int MaxV = (1 << (W-1)) - 1;
  localparam int MinV = -(1 << (W-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic countUpIn = 1'b0, countDnIn = 1'b0, clearCmd = 1'b0;
  logic [W-1:0] presetIn = '0;
  logic [W-1:0] accOut;
  logic doneOut, ovfOut, udfOut, upEnOut, dnEnOut;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int expAcc = 0, expPre = 0;
  int expOvf = 0, expUdf = 0;

  always #10 clk = ~clk; // 50 MHz

  rung_counter #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .countUpIn(countUpIn), .countDnIn(countDnIn),
    .clearCmd(clearCmd), .presetIn(presetIn), .accOut(accOut), .doneOut(doneOut),
    .ovfOut(ovfOut), .udfOut(udfOut), .upEnOut(upEnOut), .dnEnOut(dnEnOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sacc();
    return $signed(accOut);
  endfunction

  task automatic checkState(input string req);
    check({req, " acc"}, sacc(), expAcc);
    check({req, " ovf"}, ovfOut, expOvf);
    check({req, " udf"}, udfOut, expUdf);
    check({req, " done R9"}, doneOut, (expAcc >= expPre) ? 1 : 0);
  endtask

  task automatic doClear(input int pre);
    @(negedge clk);
    clearCmd = 1'b1; presetIn = pre[W-1:0]; expPre = pre;
    @(negedge clk);
    clearCmd = 1'b0;
    expAcc = 0; expOvf = 0; expUdf = 0;
    check("R7 acc", sacc(), 0);
    check("R7 done", doneOut, 0);
    check("R7 flags", ovfOut | udfOut, 0);
    @(negedge clk);
  endtask

  task automatic pulseUp();
    countUpIn = 1'b1;
    @(negedge clk);
    check("R10 upEn", upEnOut, 1);
    countUpIn = 1'b0;
    if (expAcc == MaxV) begin expAcc = MinV; expOvf = 1; end
    else expAcc = expAcc + 1;
    @(negedge clk);
  endtask

  task automatic pulseDn();
    countDnIn = 1'b1;
    @(negedge clk);
    check("R10 dnEn", dnEnOut, 1);
    countDnIn = 1'b0;
    if (expAcc == MinV) begin expAcc = MaxV; expUdf = 1; end
    else expAcc = expAcc - 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 acc", sacc(), 0);
    check("R1 flags", {doneOut, ovfOut, udfOut, upEnOut, dnEnOut}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep every preset; run the count up through and past both wraps.
    for (int p = MinV; p <= MaxV; p++) begin
      doClear(p);
      for (int i = 0; i < 2 * (MaxV - MinV + 1) + 3; i++) begin
        pulseUp();
        checkState((expOvf != 0) ? "R4/R6 up" : "R2 up");
      end
      for (int i = 0; i < 2 * (MaxV - MinV + 1) + 3; i++) begin
        pulseDn();
        checkState((expUdf != 0) ? "R5/R6 dn" : "R3 dn");
      end
    end

    // Held level counts once.
    doClear(2);
    countUpIn = 1'b1;
    repeat (5) @(negedge clk);
    expAcc = 1;
    checkState("R2 held");
    countUpIn = 1'b0;
    @(negedge clk);
    check("R10 upEn low", upEnOut, 0);
    countDnIn = 1'b1;
    repeat (5) @(negedge clk);
    expAcc = 0;
    checkState("R3 held");
    countDnIn = 1'b0;
    @(negedge clk);

    // Simultaneous edges leave the count alone.
    pulseUp(); pulseUp();
    countUpIn = 1'b1; countDnIn = 1'b1;
    @(negedge clk);
    check("R8 both", sacc(), 2);
    check("R10 both en", {upEnOut, dnEnOut}, 3);
    countUpIn = 1'b0; countDnIn = 1'b0;
    @(negedge clk);
    check("R8 after", sacc(), 2);

    // Clear beats a same-clock edge.
    countUpIn = 1'b1; clearCmd = 1'b1;
    @(negedge clk);
    countUpIn = 1'b0; clearCmd = 1'b0;
    check("R7 priority acc", sacc(), 0);
    check("R7 priority done", doneOut, 0);
    @(negedge clk);
    expAcc = 0;
    checkState("R9 after clear");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule